// File: doc/BRIEF.md
# Multi-Port Serial Card I/O Address Decoder

This block sits between a 16-bit I/O address bus and a bank of four or eight UART channels on one expansion card. It compares the upper address lines against a bank of configuration switches and works out whether the current I/O cycle belongs to the card. If it does, the block selects exactly one channel and passes on the register offset inside that channel. The card occupies a contiguous window. Each channel owns eight consecutive byte addresses, and channel n (counting from 1) starts at base + 8·(n−1).

The switches are inverted. A closed switch demands a 0 on its address line and an open switch demands a 1. A variant input sets the card size. The four-port card spans 32 bytes and compares one more address line than the eight-port card, which spans 64 bytes. A second switch can reroute offset 7 of every channel to a single card-wide status register, which replaces the per-channel scratchpad location. All outputs are registered and appear one clock after the bus inputs.

Top module: `sercard_decode`

## Requirements
- R1: While rstN is low, cardHit, chanSel, statSel and regOff are all zero.
- R2: swClosed[i] governs address line A(i+5). A 1 (closed) requires that line to be 0 and a 0 (open) requires it to be 1, so all-open switches place the base at 0xFFE0 on the four-port card.
- R3: With wideCard=1 (eight ports), the card is hit when A15..A6 match the switches and swClosed[0] is ignored. Channel index A5..A3 (0..7) drives chanSel bit equal to that index.
- R4: With wideCard=0 (four ports), the card is hit when A15..A5 match the switches. Channel index A4..A3 (0..3) drives the matching chanSel bit, and chanSel[7:4] stay 0.
- R5: cardHit, chanSel and statSel are asserted only for a cycle in which ioRd or ioWr was high; with both low all three are 0.
- R6: With statEn=1, an access at offset 7 (A2..A0 = 3'b111) of any channel raises statSel and leaves chanSel all zero. With statEn=0 that access selects the channel like any other offset.
- R7: regOff equals A2..A0 of the previous cycle, whether or not the card is hit.
- R8: At most one of the nine targets (chanSel bits, statSel) is high in any cycle, and cardHit is high exactly when one of them is.
- R9: Outputs change only at a rising clock edge, one cycle after the inputs that cause them.
- R10: With switches encoding 0x300, the four-port card answers 0x300..0x31F and the eight-port card answers 0x300..0x33F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 16 | I/O address bus A15..A0 |
| ioRd | input | 1 | I/O read strobe, active high |
| ioWr | input | 1 | I/O write strobe, active high |
| swClosed | input | 11 | Base switches for A15..A5, 1 = closed |
| wideCard | input | 1 | 1 = eight-port card, 0 = four-port card |
| statEn | input | 1 | 1 = offset 7 goes to the shared status register |
| cardHit | output | 1 | Registered: the access falls in the card window |
| chanSel | output | 8 | Registered one-hot channel select |
| statSel | output | 1 | Registered status register select |
| regOff | output | 3 | Registered register offset A2..A0 |

## Verification
The bench builds the block with its defaults: a 16-bit address, 3 offset bits, and between four and eight channels. That size lets it sweep every address in a 192-byte span around each of five switch settings. The sweep covers both card sizes, both status options and all three strobe states. The span reaches both window edges and the neighbouring blocks, and some settings differ only in A5, which exposes the extra compare line of the four-port card. Expected selects are computed from the switch value with masks and integer division.

// File: rtl/sercard_decode_pkg.sv
package sercard_decode_pkg;
  // Strobes handed from the compare control to the select datapath
  typedef struct packed {
    logic access;     // a read or write strobe is active
    logic inWindow;   // upper address lines match the switches
    logic statRoute;  // offset 7 goes to the shared status register
  } decStrobe_t;
endpackage

// File: rtl/sercard_decode_ctrl.sv
module sercard_decode_ctrl
  import sercard_decode_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 3,
  parameter int CH_MAX = 8,
  parameter int CH_MIN = 4,
  localparam int CH_W     = $clog2(CH_MAX),
  localparam int CH_MIN_W = $clog2(CH_MIN),
  localparam int SW_W     = ADDR_W - OFF_W - CH_MIN_W,
  localparam int EXTRA    = CH_W - CH_MIN_W
) (
  input  logic [SW_W-1:0]  upperAddr,
  input  logic [OFF_W-1:0] offAddr,
  input  logic             ioRd,
  input  logic             ioWr,
  input  logic [SW_W-1:0]  swClosed,
  input  logic             wideCard,
  input  logic             statEn,
  output decStrobe_t       strobes
);

  logic [SW_W-1:0] cmpOk;

  // Closed switch demands 0, open switch demands 1; the lowest EXTRA
  // lines belong to the channel index on the wide card and are skipped.
  for (genvar i = 0; i < SW_W; i++) begin : g_cmp
    if (i < EXTRA) begin : g_opt
      assign cmpOk[i] = wideCard | (upperAddr[i] == ~swClosed[i]);
    end else begin : g_fix
      assign cmpOk[i] = (upperAddr[i] == ~swClosed[i]);
    end
  end

  always_comb begin
    strobes.access    = ioRd | ioWr;
    strobes.inWindow  = &cmpOk;
    strobes.statRoute = statEn & (&offAddr);
  end

endmodule

// File: rtl/sercard_decode_dp.sv
module sercard_decode_dp
  import sercard_decode_pkg::*;
#(
  parameter int OFF_W  = 3,
  parameter int CH_MAX = 8,
  parameter int CH_MIN = 4,
  localparam int CH_W     = $clog2(CH_MAX),
  localparam int CH_MIN_W = $clog2(CH_MIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CH_W-1:0]   chanAddr,
  input  logic [OFF_W-1:0]  offAddr,
  input  logic              wideCard,
  input  decStrobe_t        strobes,
  output logic              cardHit,
  output logic [CH_MAX-1:0] chanSel,
  output logic              statSel,
  output logic [OFF_W-1:0]  regOff
);

  logic [CH_W-1:0]   chanIdx;
  logic [CH_MAX-1:0] selNext;
  logic              hitNow;

  // Index bits above the narrow card's range count only on the wide card
  for (genvar j = 0; j < CH_W; j++) begin : g_idx
    if (j < CH_MIN_W) begin : g_low
      assign chanIdx[j] = chanAddr[j];
    end else begin : g_high
      assign chanIdx[j] = wideCard & chanAddr[j];
    end
  end

  assign hitNow = strobes.access & strobes.inWindow;

  for (genvar c = 0; c < CH_MAX; c++) begin : g_sel
    assign selNext[c] = hitNow & ~strobes.statRoute & (chanIdx == CH_W'(c));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cardHit <= 1'b0;
      chanSel <= '0;
      statSel <= 1'b0;
      regOff  <= '0;
    end else begin
      cardHit <= hitNow;
      chanSel <= selNext;
      statSel <= hitNow & strobes.statRoute;
      regOff  <= offAddr;
    end
  end

endmodule

// File: rtl/sercard_decode.sv
module sercard_decode
  import sercard_decode_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 3,
  parameter int CH_MAX = 8,
  parameter int CH_MIN = 4,
  localparam int CH_W     = $clog2(CH_MAX),
  localparam int CH_MIN_W = $clog2(CH_MIN),
  localparam int SW_W     = ADDR_W - OFF_W - CH_MIN_W,
  localparam int LOW_BIT  = OFF_W + CH_MIN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [SW_W-1:0]   swClosed,
  input  logic              wideCard,
  input  logic              statEn,
  output logic              cardHit,
  output logic [CH_MAX-1:0] chanSel,
  output logic              statSel,
  output logic [OFF_W-1:0]  regOff
);

  decStrobe_t strobes;

  sercard_decode_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CH_MAX(CH_MAX), .CH_MIN(CH_MIN)
  ) i_ctrl (
    .upperAddr(ioAddr[ADDR_W-1:LOW_BIT]),
    .offAddr  (ioAddr[OFF_W-1:0]),
    .ioRd     (ioRd),
    .ioWr     (ioWr),
    .swClosed (swClosed),
    .wideCard (wideCard),
    .statEn   (statEn),
    .strobes  (strobes)
  );

  sercard_decode_dp #(
    .OFF_W(OFF_W), .CH_MAX(CH_MAX), .CH_MIN(CH_MIN)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .chanAddr(ioAddr[OFF_W+CH_W-1:OFF_W]),
    .offAddr (ioAddr[OFF_W-1:0]),
    .wideCard(wideCard),
    .strobes (strobes),
    .cardHit (cardHit),
    .chanSel (chanSel),
    .statSel (statSel),
    .regOff  (regOff)
  );

endmodule

// File: rtl/sercard_decode_chk.sv
module sercard_decode_chk #(
  parameter int OFF_W  = 3,
  parameter int CH_MAX = 8,
  parameter int CH_MIN = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [OFF_W-1:0]  ioAddrLow,
  input logic              ioRd,
  input logic              ioWr,
  input logic              wideCard,
  input logic              statEn,
  input logic              cardHit,
  input logic [CH_MAX-1:0] chanSel,
  input logic              statSel,
  input logic [OFF_W-1:0]  regOff
);

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({chanSel, statSel})); // R8

  AST_HIT_HAS_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    cardHit == ((chanSel != '0) || statSel)); // R8

  AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    !(ioRd || ioWr) |=> (!cardHit && chanSel == '0 && !statSel)); // R5

  AST_NARROW_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !wideCard |=> (chanSel[CH_MAX-1:CH_MIN] == '0)); // R4

  AST_STAT_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (statEn && (&ioAddrLow)) |=> (chanSel == '0)); // R6

  AST_STAT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    !statEn |=> !statSel); // R6

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (regOff == $past(ioAddrLow))); // R7

endmodule

bind sercard_decode sercard_decode_chk #(
  .OFF_W(OFF_W), .CH_MAX(CH_MAX), .CH_MIN(CH_MIN)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ioAddrLow(ioAddr[OFF_W-1:0]),
  .ioRd     (ioRd),
  .ioWr     (ioWr),
  .wideCard (wideCard),
  .statEn   (statEn),
  .cardHit  (cardHit),
  .chanSel  (chanSel),
  .statSel  (statSel),
  .regOff   (regOff)
);

// File: tb/test_sercard_decode.sv
`timescale 1ns/1ps
module test_sercard_decode;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioRd = 1'b0;
  logic        ioWr = 1'b0;
  logic [10:0] swClosed = '0;
  logic        wideCard = 1'b0;
  logic        statEn = 1'b0;
  logic        cardHit;
  logic [7:0]  chanSel;
  logic        statSel;
  logic [2:0]  regOff;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  sercard_decode i_sercard_decode (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .swClosed(swClosed), .wideCard(wideCard), .statEn(statEn),
    .cardHit(cardHit), .chanSel(chanSel), .statSel(statSel), .regOff(regOff)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s addr=%h wide=%0d stat=%0d actual=%h expected=%h",
               tag, what, ioAddr, wideCard, statEn, act, exp);
    end
  endtask

  // Switch setting for a base: closed (1) where the base bit is 0
  function automatic logic [10:0] swFor(input logic [15:0] base);
    return ~base[15:5];
  endfunction

  // Drive one bus cycle at a falling edge, check after the next rising edge
  task automatic access(input logic [15:0] a, input logic r, input logic w);
    logic [15:0] baseVal, mask;
    logic        hit, isStat;
    int          ch;
    int          expSel;
    string       tag;
    @(negedge clk);
    ioAddr = a; ioRd = r; ioWr = w;
    @(negedge clk);
    baseVal = {~swClosed, 5'b0};
    mask    = wideCard ? 16'hFFC0 : 16'hFFE0;
    hit     = ((a & mask) == (baseVal & mask)) && (r || w);
    ch      = int'(a - (baseVal & mask)) / 8;
    isStat  = statEn && (a[2:0] == 3'd7);
    expSel  = (hit && !isStat) ? (1 << ch) : 0;
    tag     = !(r || w) ? "R5" : (wideCard ? "R3" : "R4");
    check(tag, "cardHit", int'(cardHit), int'(hit));
    check(isStat ? "R6" : tag, "chanSel", int'(chanSel), expSel);
    check("R6", "statSel", int'(statSel), int'(hit && isStat));
    check("R7", "regOff", int'(regOff), int'(a[2:0]));
    check("R8", "oneTarget", $countones({chanSel, statSel}), int'(hit));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] bases [5];
    bases = '{16'h0300, 16'h5AC0, 16'h0000, 16'hFFE0, 16'h5AE0};

    // R1: reset state with a hitting access on the bus
    swClosed = swFor(16'h0300);
    ioAddr = 16'h0307; ioRd = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "cardHit", int'(cardHit), 0);
    check("R1", "chanSel", int'(chanSel), 0);
    check("R1", "statSel", int'(statSel), 0);
    check("R1", "regOff", int'(regOff), 0);
    ioRd = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // R9: nothing moves before the rising edge, selection after it
    access(16'h0000, 1'b0, 1'b0);
    ioAddr = 16'h0308; ioRd = 1'b1;
    #5;
    check("R9", "chanSel before edge", int'(chanSel), 0);
    @(negedge clk);
    check("R9", "chanSel after edge", int'(chanSel), 2);
    ioRd = 1'b0;

    // R10: default base 0x300, window ends per card size
    wideCard = 1'b0;
    access(16'h031F, 1'b1, 1'b0);
    check("R10", "narrow last byte", int'(chanSel), 8);
    access(16'h0320, 1'b1, 1'b0);
    check("R10", "narrow past end", int'(cardHit), 0);
    wideCard = 1'b1;
    access(16'h033F, 1'b0, 1'b1);
    check("R10", "wide last byte", int'(chanSel), 128);
    access(16'h0340, 1'b0, 1'b1);
    check("R10", "wide past end", int'(cardHit), 0);

    // R2: all switches open put the narrow base at 0xFFE0
    wideCard = 1'b0;
    swClosed = '0;
    access(16'hFFE0, 1'b1, 1'b0);
    check("R2", "open switches hit top", int'(cardHit), 1);
    access(16'h0000, 1'b1, 1'b0);
    check("R2", "open switches miss zero", int'(cardHit), 0);
    swClosed = '1;
    access(16'h0000, 1'b1, 1'b0);
    check("R2", "closed switches hit zero", int'(cardHit), 1);

    // Sweep: every base, card size, status option and strobe state
    foreach (bases[b]) begin
      swClosed = swFor(bases[b]);
      for (int wv = 0; wv < 2; wv++) begin
        wideCard = wv[0];
        for (int sv = 0; sv < 2; sv++) begin
          statEn = sv[0];
          for (int mode = 0; mode < 3; mode++) begin
            for (int k = -64; k < 128; k++) begin
              logic [15:0] a;
              a = (bases[b] & 16'hFFC0) + 16'(k);
              access(a, mode == 0, mode == 1);
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule